// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external 128K x 8 asynchronous static RAM. The host hands over one word request at a time through a valid/ready handshake, carrying a write flag, a 17-bit address and, for writes, one byte of data. The controller turns each request into a timed pin sequence for the memory: a low-active select and a high-active select driven as a pair, an output enable, a write enable, and a split data bus made of an output byte, an input byte and a drive enable for the pad.

Every phase of the sequence is counted in clock cycles. Each phase length comes from a parameter, and it is raised to the smallest count that still meets the memory's nanosecond minimum at the configured clock period. A write has four phases. In the setup phase the address and selects are presented with the write strobe high. The strobe then goes low with data driven. After that comes one hold cycle in which the strobe has risen but data and selects remain. Last is a turnaround with everything released. A read keeps the output enable low for the access phase, samples the input byte on the last clock of that phase, and then runs the same turnaround. Read data returns with a one-cycle valid pulse. That return path has no ready signal, so the host must always be able to take the byte.

Back-pressure on the request side is simple. `req_ready` is high only while the controller is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The fields are captured at that edge, so the host may change them afterwards. A host that keeps `req_valid` high just waits until the next idle cycle.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held and whenever the controller is idle, the pins read `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, and `req_ready`=1 with `rd_valid`=0.
- R2: The two selects always switch together (`mem_ce_n` is the inverse of `mem_ce`). The memory is selected only when `mem_ce_n`=0 and `mem_ce`=1.
- R3: A read holds `mem_oe_n`=0 and `mem_we_n`=1 with the memory selected for the access phase (default 4 cycles). It captures `mem_dq_in` on the final clock of that phase and raises `rd_valid` for exactly one cycle, starting the cycle after, with the captured byte on `rd_data`.
- R4: A write presents the address and selects with `mem_we_n`=1 for the setup phase (default 1 cycle). It then holds `mem_we_n`=0 for exactly the pulse phase (default 3 cycles), with the address unchanged while the strobe falls.
- R5: `mem_dq_oe`=1 whenever `mem_we_n`=0. In the cycle where `mem_we_n` rises, the data byte, the address, the selects and `mem_dq_oe` are all unchanged, so the write ends on the strobe edge with data held through it.
- R6: `mem_dq_oe` and `mem_oe_n`=0 are never both active. `mem_dq_oe` only rises after `mem_oe_n` has been high for at least the turnaround phase (default 1 cycle).
- R7: After a request is taken, `req_ready` stays low until the sequence ends. That is setup+pulse+1+turnaround cycles for a write (6 by default) and access+turnaround cycles for a read (5 by default).
- R8: `req_valid` pulses while `req_ready` is low are ignored. They cause no memory write and no read data.
- R9: Each phase length is the larger of its parameter and the memory minimum rounded up to whole clocks: 25 ns for the strobe pulse, 35 ns for the read access, 10 ns for turnaround, and at least 1 cycle for every phase. For example, at a 20 ns period with all parameters set to 1, the strobe is low for 2 cycles and a read is busy for 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to store on a write |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` |
| rd_data | output | 8 | Byte returned by a read |
| mem_addr | output | 17 | Memory address bus |
| mem_ce_n | output | 1 | Active-low memory select |
| mem_ce | output | 1 | Active-high memory select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_in | input | 8 | Byte received from the memory |
| mem_dq_oe | output | 1 | Pad drive enable for `mem_dq_out` |

## Verification
The bound checker watches the pin-level rules on every cycle. These cover the idle pin state whenever ready is high, the paired selects, and the rule that the output enable and the bus drive are never active together. They also cover the turnaround count before any drive, the exact strobe width, the held data and address at the strobe's rising edge, and the single-cycle read strobe. Other behaviours only the bench's scenarios can show. These include whether a byte actually lands at the right address and comes back intact, and whether data is sampled late enough to be valid from a memory model with access delay. They also include the busy length per request type, the stray requests during a busy period that must leave no trace, and the rounding of short phase parameters at a slower clock.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACCESS,
    ST_TURN
  } ctrl_st_e;

  typedef struct packed {
    logic ce_n;
    logic ce;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } mem_pins_t;

  localparam int unsigned PULSE_MIN_NS  = 25;
  localparam int unsigned ACCESS_MIN_NS = 35;
  localparam int unsigned TURN_MIN_NS   = 10;
  localparam int unsigned SETUP_MIN_NS  = 0;

  // Smallest whole-clock count that covers min_ns, never below req or 1.
  function automatic int unsigned phase_cycles(int unsigned req, int unsigned min_ns,
                                               int unsigned clk_ns);
    int unsigned r;
    r = (min_ns + clk_ns - 1) / clk_ns;
    if (req > r) r = req;
    if (r < 1) r = 1;
    return r;
  endfunction

  function automatic mem_pins_t pins_for(ctrl_st_e s);
    mem_pins_t p;
    p = '{ce_n: 1'b1, ce: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    case (s)
      ST_WSETUP:  begin p.ce_n = 1'b0; p.ce = 1'b1; end
      ST_WPULSE:  begin p.ce_n = 1'b0; p.ce = 1'b1; p.we_n = 1'b0; p.dq_oe = 1'b1; end
      ST_WHOLD:   begin p.ce_n = 1'b0; p.ce = 1'b1; p.dq_oe = 1'b1; end
      ST_RACCESS: begin p.ce_n = 1'b0; p.ce = 1'b1; p.oe_n = 1'b0; end
      default:    ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= len - CNT_W'(1);
    else if (cnt != '0)      cnt <= cnt - CNT_W'(1);
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= capture;
      if (capture) dout <= din;
    end
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW     = 17,
  parameter int DW     = 8,
  parameter int CLK_NS = 10,
  parameter int T_ASU  = 1,
  parameter int T_WE   = 3,
  parameter int T_ACC  = 4,
  parameter int T_TA   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_dq_oe
);
  localparam int unsigned ASU_C = phase_cycles(T_ASU, SETUP_MIN_NS, CLK_NS);
  localparam int unsigned WE_C  = phase_cycles(T_WE, PULSE_MIN_NS, CLK_NS);
  localparam int unsigned ACC_C = phase_cycles(T_ACC, ACCESS_MIN_NS, CLK_NS);
  localparam int unsigned TA_C  = phase_cycles(T_TA, TURN_MIN_NS, CLK_NS);
  localparam int unsigned MAX_A = (ASU_C > WE_C) ? ASU_C : WE_C;
  localparam int unsigned MAX_B = (ACC_C > TA_C) ? ACC_C : TA_C;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  ctrl_st_e         st, st_n;
  logic             tmr_load, tmr_done, cap;
  logic [CNT_W-1:0] tmr_len;
  logic             accept;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  mem_pins_t        pins_q, pins_n;

  assign accept = req_valid && (st == ST_IDLE);

  always_comb begin
    st_n     = st;
    tmr_load = 1'b0;
    tmr_len  = CNT_W'(1);
    cap      = 1'b0;
    case (st)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (req_write) begin st_n = ST_WSETUP;  tmr_len = CNT_W'(ASU_C); end
        else           begin st_n = ST_RACCESS; tmr_len = CNT_W'(ACC_C); end
      end
      ST_WSETUP: if (tmr_done) begin
        st_n = ST_WPULSE; tmr_load = 1'b1; tmr_len = CNT_W'(WE_C);
      end
      ST_WPULSE: if (tmr_done) begin
        st_n = ST_WHOLD; tmr_load = 1'b1; tmr_len = CNT_W'(1);
      end
      ST_WHOLD: if (tmr_done) begin
        st_n = ST_TURN; tmr_load = 1'b1; tmr_len = CNT_W'(TA_C);
      end
      ST_RACCESS: if (tmr_done) begin
        cap = 1'b1; st_n = ST_TURN; tmr_load = 1'b1; tmr_len = CNT_W'(TA_C);
      end
      ST_TURN: if (tmr_done) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  assign pins_n = pins_for(st_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pins_q  <= pins_for(ST_IDLE);
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st     <= st_n;
      pins_q <= pins_n;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (tmr_load),
    .len  (tmr_len),
    .done (tmr_done)
  );

  sram_rd_capture #(.DW(DW)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(cap),
    .din    (mem_dq_in),
    .dout   (rd_data),
    .valid  (rd_valid)
  );

  assign req_ready  = (st == ST_IDLE);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_ce_n   = pins_q.ce_n;
  assign mem_ce     = pins_q.ce;
  assign mem_we_n   = pins_q.we_n;
  assign mem_oe_n   = pins_q.oe_n;
  assign mem_dq_oe  = pins_q.dq_oe;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int AW     = 17,
  parameter int DW     = 8,
  parameter int CLK_NS = 10,
  parameter int T_WE   = 3,
  parameter int T_TA   = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rd_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_ce,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);
  localparam int unsigned WE_C = phase_cycles(T_WE, PULSE_MIN_NS, CLK_NS);
  localparam int unsigned TA_C = phase_cycles(T_TA, TURN_MIN_NS, CLK_NS);

  logic [15:0] we_lo_cnt;
  logic [15:0] oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      oe_hi_cnt <= '1;
    end else begin
      we_lo_cnt <= mem_we_n ? 16'd0 : we_lo_cnt + 16'd1;
      if (!mem_oe_n)              oe_hi_cnt <= '0;
      else if (oe_hi_cnt != '1)   oe_hi_cnt <= oe_hi_cnt + 16'd1;
    end
  end

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe));

  a_r2_select_pair: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n == !mem_ce);

  a_r3_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r4_addr_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_ce_n) && $stable(mem_addr)));

  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt == 16'(WE_C)));

  a_r5_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  a_r5_hold_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_dq_out) && $stable(mem_addr)));

  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi_cnt >= 16'(TA_C)));

  a_r7_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
  .AW(AW), .DW(DW), .CLK_NS(CLK_NS), .T_WE(T_WE), .T_TA(T_TA)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_ce    (mem_ce),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_out(mem_dq_out),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  logic        s_valid = 1'b0, s_write = 1'b0;
  logic [16:0] s_addr = '0;
  logic [7:0]  s_wdata = '0;
  logic        s_ready, s_rd_valid;
  logic [7:0]  s_rd_data;
  logic [16:0] s_mem_addr;
  logic        s_ce_n, s_ce, s_we_n, s_oe_n, s_dq_oe;
  logic [7:0]  s_dq_out;

  always #10 clk = ~clk;

  sram_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  sram_seq_ctrl #(.CLK_NS(20), .T_ASU(1), .T_WE(1), .T_ACC(1), .T_TA(1)) uut_slow (
    .clk(clk), .rst_n(rst_n), .req_valid(s_valid), .req_ready(s_ready),
    .req_write(s_write), .req_addr(s_addr), .req_wdata(s_wdata),
    .rd_valid(s_rd_valid), .rd_data(s_rd_data), .mem_addr(s_mem_addr),
    .mem_ce_n(s_ce_n), .mem_ce(s_ce), .mem_we_n(s_we_n), .mem_oe_n(s_oe_n),
    .mem_dq_out(s_dq_out), .mem_dq_in(8'h5A), .mem_dq_oe(s_dq_oe)
  );

  int n_chk = 0, n_bad = 0, clash = 0, rcnt = 0;
  bit finished = 1'b0;
  logic [7:0] model_mem [int];
  logic [7:0] ref_mem [int];
  logic [7:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Memory model: write on strobe release, data valid after 3 selected read clocks.
  always @(posedge mem_we_n)
    if (rst_n && !mem_ce_n && mem_ce && mem_dq_oe) model_mem[int'(mem_addr)] = mem_dq_out;

  always @(posedge clk)
    rcnt <= (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n) ? rcnt + 1 : 0;

  always @* begin
    mem_dq_in = 8'hEE;
    if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n && rcnt >= 3)
      mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected read data", int'(rd_data), 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R3 read data", int'(rd_data), int'(e));
      end
    end
    if (rst_n && mem_dq_oe && !mem_oe_n) clash++;
  end

  task automatic do_write(input logic [16:0] a, input logic [7:0] d, input bit stray,
                          output int busy, output int welo, output int setup);
    bit seen;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0; welo = 0; setup = 0; seen = 1'b0;
    while (!req_ready) begin
      busy++;
      if (!mem_we_n) begin welo++; seen = 1'b1; end
      else if (!mem_ce_n && !seen) setup++;
      req_valid = stray && (busy == 2);
      if (stray && busy == 2) begin
        req_write = 1'b1; req_addr = 17'h0ABCD; req_wdata = 8'hC3;
      end
      @(negedge clk);
      req_valid = 1'b0;
    end
    ref_mem[int'(a)] = d;
  endtask

  task automatic do_read(input logic [16:0] a, output int busy);
    while (!req_ready) @(negedge clk);
    exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready) begin busy++; @(negedge clk); end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int busy, welo, setup;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_ce_n == 1'b1, "R1 ce_n in reset", int'(mem_ce_n), 1);
    chk(mem_ce == 1'b0, "R1 ce in reset", int'(mem_ce), 0);
    chk(mem_we_n && mem_oe_n, "R1 strobes in reset", int'({mem_we_n, mem_oe_n}), 3);
    chk(mem_dq_oe == 1'b0, "R1 drive off in reset", int'(mem_dq_oe), 0);
    chk(req_ready && !rd_valid, "R1 handshake in reset", int'({req_ready, rd_valid}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_ce_n && !mem_ce, "R1 idle after reset", int'({req_ready, mem_ce_n, mem_ce}), 6);

    do_write(17'h00000, 8'h11, 1'b0, busy, welo, setup);
    chk(busy == 6, "R7 write busy cycles", busy, 6);
    chk(welo == 3, "R4 strobe low cycles", welo, 3);
    chk(setup == 1, "R4 setup cycles", setup, 1);
    do_write(17'h1FFFF, 8'hA5, 1'b0, busy, welo, setup);

    // R8: stray request during busy write
    do_write(17'h12345, 8'h3C, 1'b1, busy, welo, setup);
    repeat (2) @(negedge clk);
    chk(req_ready && !rd_valid, "R8 stray left no pending work", int'({req_ready, rd_valid}), 2);
    chk(!model_mem.exists(32'h0ABCD), "R8 stray not written", int'(model_mem.exists(32'h0ABCD)), 0);

    do_read(17'h12345, busy);
    chk(busy == 5, "R7 read busy cycles", busy, 5);
    do_read(17'h1FFFF, busy);
    do_read(17'h00000, busy);
    do_read(17'h0ABCD, busy);

    // R6: write immediately followed by read, then overwrite
    do_write(17'h000F0, 8'h77, 1'b0, busy, welo, setup);
    do_read(17'h000F0, busy);
    do_write(17'h1FFFF, 8'h5A, 1'b0, busy, welo, setup);
    do_read(17'h1FFFF, busy);
    do_read(17'h1FFFF, busy);

    for (int i = 1; i <= 8; i++)
      do_write(17'(i * 32'h3001), 8'(i * 37 + 1), 1'b0, busy, welo, setup);
    for (int i = 8; i >= 1; i--)
      do_read(17'(i * 32'h3001), busy);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);
    chk(clash == 0, "R6 no bus contention", clash, 0);

    // R9: rounded phases on the slow instance
    s_valid = 1'b1; s_write = 1'b1; s_addr = 17'h00005; s_wdata = 8'h42;
    @(negedge clk);
    s_valid = 1'b0;
    busy = 0; welo = 0;
    while (!s_ready) begin
      busy++;
      if (!s_we_n) welo++;
      @(negedge clk);
    end
    chk(welo == 2, "R9 rounded strobe width", welo, 2);
    chk(busy == 5, "R9 rounded write busy", busy, 5);
    s_valid = 1'b1; s_write = 1'b0;
    @(negedge clk);
    s_valid = 1'b0;
    busy = 0; setup = 0;
    while (!s_ready) begin
      busy++;
      if (s_rd_valid) begin
        setup++;
        chk(s_rd_data == 8'h5A, "R9 slow read data", int'(s_rd_data), 8'h5A);
      end
      @(negedge clk);
    end
    chk(busy == 3, "R9 rounded read busy", busy, 3);
    chk(setup == 1, "R3 slow read valid pulse", setup, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule